// File: doc/BRIEF.md
# DRAM Command Issue Sequencer

This block turns register writes into single DDR3 control commands addressed to one or both ranks, and it can run the DDR3 power-up bring-up order without software help. Software writes a command word with the start bit set. The block presents that command for one cycle on a plain command output: a valid strobe, the command code, the rank mask, the mode-register index and the mode-register payload. The start bit then reads back as 1 until the command's spacing window has run out, so software polls it as a busy flag.

A power-control register raises a power-up request toward the memory side, and the request falls once the done input is seen. If auto-init is enabled, the rising edge of that done input launches a fixed sequence:

- deselect, followed by a pause;
- precharge-all;
- four mode-register sets, to MR2, MR3, MR1 and MR0 in that order;
- ZQ long calibration.

The MR0 and MR2 payloads are computed from CAS latency, CAS write latency and write recovery values held in a configuration register.

Top module: `dram_cmd_seq`

## Requirements
- R1: The command word (register address 0) holds start at bit 31, a rank-1 select at bit 21, a rank-0 select at bit 20, the mode-register index at bits 19:17, the mode-register payload at bits 16:4 and the command code at bits 3:0. A write with start=1 while idle drives `dram_cmd_valid_o` for exactly one cycle, in the cycle after the write edge, carrying those fields unchanged. Both rank bits may be set at once.
- R2: Command codes 0 (deselect), 1 (precharge-all), 2 (refresh), 3 (mode-register set), 4 (ZQ short), 5 (ZQ long), 6 (reset low), 8 (mode-register read) and 9 (deep power-down entry) are driven. Any other code completes after one busy cycle without any valid strobe.
- R3: Bit 31 of register 0 reads 1 from the cycle after an accepted write until the command completes, then reads 0. Any command other than a mode-register set or a ZQ long calibration keeps it at 1 for exactly one cycle.
- R4: A command write with start=1 while the start bit reads 1 is ignored: it drives no strobe and leaves the stored command fields unchanged. It sets a sticky error flag at bit 1 of the status register (address 2). Writing 1 to that bit clears the flag.
- R5: After a mode-register set, the start bit stays 1 for max(1, tMRD) cycles, and the next strobe comes no earlier than tMRD cycles after it.
- R6: After a ZQ long calibration, the start bit stays 1 for max(1, tZQCL) cycles, and the next strobe comes no earlier than tZQCL cycles after it.
- R7: Writing 1 to bit 0 of the power-control register (address 1) raises `pwrup_start_o` from the next cycle. It falls in the cycle after `pwrup_done_i` is sampled high. Status bit 0 reads `pwrup_done_i` delayed by one register.
- R8: With auto-init enabled (bit 0 of address 4), a rising edge of `pwrup_done_i` issues seven commands, all with rank mask 2'b11:
  - deselect, with the next strobe exactly PAUSE_CYC (default 250) cycles later;
  - precharge-all, with the next strobe one cycle later;
  - mode-register sets to index 2, 3, 1 and 0, each tMRD cycles apart;
  - ZQ long calibration.

  The start bit reads 1 from the cycle after the done edge until the sequence ends.
- R9: In auto-init, the MR2 payload is ((CWL-5)&7)<<3, the MR3 payload is 0 and the MR1 payload is 0x040. The MR0 payload is ((CL-4)&7)<<4, plus ((CL-4)&8)>>2, plus bit 8 set, plus write recovery. Write recovery is (WR-4)<<9 when WR≤8 and ((WR>>1)&7)<<9 otherwise. CL sits at bits 7:4, CWL at bits 11:8 and WR at bits 16:12 of address 4.
- R10: The timing register (address 3) holds tMRD at bits 7:0 and tZQCL at bits 23:8, and resets to tMRD=4 and tZQCL=256. Address 4 resets to auto-init off with CL=6, CWL=5 and WR=6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| pwrup_start_o | output | 1 | Power-up request toward memory side |
| pwrup_done_i | input | 1 | Power-up complete indication |
| dram_cmd_valid_o | output | 1 | One-cycle command strobe |
| dram_cmd_o | output | 4 | Command code |
| dram_rank_o | output | 2 | Rank mask, bit 1 = rank 1 |
| dram_mr_idx_o | output | 3 | Mode-register index |
| dram_mr_data_o | output | 13 | Mode-register payload |

## Verification
A stuck or miscounted spacing counter shows up on the very next poll. The number of cycles the start bit reads 1 after a mode-register set or a ZQ long calibration then differs from the programmed value, so a single command exposes it. A wrong auto-init step pointer or payload encoder shows up within one power-up run as a missing, reordered or mis-spaced strobe, or as a wrong payload. Three different CL/WR/CWL sets cover both write-recovery branches and the high CAS-latency bit. A broken busy guard shows up as an extra strobe, or as an error flag that does not set, during the same window in which a rejected write was made.

// File: rtl/dcs_pkg.sv
`timescale 1ns/1ps
package dcs_pkg;
  localparam int WORD_W  = 32;
  localparam int CODE_W  = 4;
  localparam int RANK_W  = 2;
  localparam int MRIX_W  = 3;
  localparam int MRDAT_W = 13;
  localparam int TMRD_W  = 8;
  localparam int TZQ_W   = 16;

  localparam int START_BIT = 31;
  localparam int RANK_LSB  = 20;
  localparam int MRIX_LSB  = 17;
  localparam int MRDAT_LSB = 4;

  localparam int ADR_CMD  = 0;
  localparam int ADR_PWR  = 1;
  localparam int ADR_STAT = 2;
  localparam int ADR_TMG  = 3;
  localparam int ADR_INIT = 4;

  localparam logic [CODE_W-1:0] OP_DES  = 4'd0;
  localparam logic [CODE_W-1:0] OP_PREA = 4'd1;
  localparam logic [CODE_W-1:0] OP_MRS  = 4'd3;
  localparam logic [CODE_W-1:0] OP_ZQL  = 4'd5;
  localparam logic [CODE_W-1:0] OP_MRR  = 4'd8;
  localparam logic [CODE_W-1:0] OP_DPD  = 4'd9;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} eng_st_e;

  typedef struct packed {
    logic [CODE_W-1:0]  code;
    logic [RANK_W-1:0]  rank;
    logic [MRIX_W-1:0]  mr_idx;
    logic [MRDAT_W-1:0] mr_dat;
    logic               pause;
  } cmd_t;

  function automatic logic is_known(input logic [CODE_W-1:0] c);
    return (c <= 4'd6) || (c == OP_MRR) || (c == OP_DPD);
  endfunction

  function automatic logic [MRDAT_W-1:0] mr0_enc(input logic [3:0] cl, input logic [4:0] wr);
    logic [3:0] c;
    logic [4:0] w;
    logic [MRDAT_W-1:0] v;
    c = cl - 4'd4;
    w = wr - 5'd4;
    v = '0;
    v[6:4] = c[2:0];
    v[1]   = c[3];
    v[8]   = 1'b1;
    if (wr <= 5'd8) v[11:9] = w[2:0];
    else            v[11:9] = wr[3:1];
    return v;
  endfunction

  function automatic logic [MRDAT_W-1:0] mr2_enc(input logic [3:0] cwl);
    logic [3:0] c;
    logic [MRDAT_W-1:0] v;
    c = cwl - 4'd5;
    v = '0;
    v[5:3] = c[2:0];
    return v;
  endfunction
endpackage

// File: rtl/dcs_regs.sv
`timescale 1ns/1ps
module dcs_regs
  import dcs_pkg::*;
#(
  parameter int AW        = 3,
  parameter int TMRD_RST  = 4,
  parameter int TZQCL_RST = 256,
  parameter int CL_RST    = 6,
  parameter int CWL_RST   = 5,
  parameter int WR_RST    = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [WORD_W-1:0]   rdata_o,
  input  logic                busy_i,
  output logic                cmd_acc_o,
  output cmd_t                sw_cmd_o,
  output logic                pwr_req_o,
  input  logic                pwr_done_i,
  output logic                err_o,
  output logic [TMRD_W-1:0]   tmrd_o,
  output logic [TZQ_W-1:0]    tzqcl_o,
  output logic [3:0]          cl_o,
  output logic [3:0]          cwl_o,
  output logic [4:0]          wr_o,
  output logic                init_trig_o
);
  logic wr_cmd, reject;
  logic done_q, auto_q;
  cmd_t cmd_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[30:24];
  assign wr_cmd    = we_i && (addr_i == AW'(ADR_CMD)) && wdata_i[START_BIT];
  assign cmd_acc_o = wr_cmd && !busy_i;
  assign reject    = wr_cmd && busy_i;

  always_comb begin
    sw_cmd_o.code   = wdata_i[CODE_W-1:0];
    sw_cmd_o.rank   = wdata_i[RANK_LSB +: RANK_W];
    sw_cmd_o.mr_idx = wdata_i[MRIX_LSB +: MRIX_W];
    sw_cmd_o.mr_dat = wdata_i[MRDAT_LSB +: MRDAT_W];
    sw_cmd_o.pause  = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      err_o     <= 1'b0;
      pwr_req_o <= 1'b0;
      done_q    <= 1'b0;
      auto_q    <= 1'b0;
      tmrd_o    <= TMRD_W'(TMRD_RST);
      tzqcl_o   <= TZQ_W'(TZQCL_RST);
      cl_o      <= 4'(CL_RST);
      cwl_o     <= 4'(CWL_RST);
      wr_o      <= 5'(WR_RST);
    end else begin
      done_q <= pwr_done_i;
      if (cmd_acc_o) cmd_q <= sw_cmd_o;
      if (reject) err_o <= 1'b1;
      else if (we_i && addr_i == AW'(ADR_STAT) && wdata_i[1]) err_o <= 1'b0;
      if (pwr_done_i) pwr_req_o <= 1'b0;
      else if (we_i && addr_i == AW'(ADR_PWR) && wdata_i[0]) pwr_req_o <= 1'b1;
      if (we_i && addr_i == AW'(ADR_TMG)) begin
        tmrd_o  <= wdata_i[7:0];
        tzqcl_o <= wdata_i[23:8];
      end
      if (we_i && addr_i == AW'(ADR_INIT)) begin
        auto_q <= wdata_i[0];
        cl_o   <= wdata_i[7:4];
        cwl_o  <= wdata_i[11:8];
        wr_o   <= wdata_i[16:12];
      end
    end
  end

  assign init_trig_o = pwr_done_i && !done_q && auto_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(ADR_CMD):  rdata_o = {busy_i, 9'b0, cmd_q.rank, cmd_q.mr_idx, cmd_q.mr_dat, cmd_q.code};
      AW'(ADR_PWR):  rdata_o = {31'b0, pwr_req_o};
      AW'(ADR_STAT): rdata_o = {30'b0, err_o, done_q};
      AW'(ADR_TMG):  rdata_o = {8'b0, tzqcl_o, tmrd_o};
      AW'(ADR_INIT): rdata_o = {15'b0, wr_o, cwl_o, cl_o, 3'b0, auto_q};
      default:       rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dcs_init_seq.sv
`timescale 1ns/1ps
module dcs_init_seq
  import dcs_pkg::*;
#(
  parameter logic [MRDAT_W-1:0] MR1_VAL = 13'h040
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_i,
  input  logic       acc_i,
  input  logic [3:0] cl_i,
  input  logic [3:0] cwl_i,
  input  logic [4:0] wr_i,
  output logic       active_o,
  output cmd_t       cmd_o
);
  localparam int NSTEP = 7;
  localparam int SW    = $clog2(NSTEP);

  logic [SW-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      step_q   <= '0;
    end else if (!active_o) begin
      if (trig_i) begin
        active_o <= 1'b1;
        step_q   <= '0;
      end
    end else if (acc_i) begin
      if (step_q == SW'(NSTEP-1)) active_o <= 1'b0;
      else step_q <= step_q + 1'b1;
    end
  end

  // fixed bring-up order: DES, PREA, MR2, MR3, MR1, MR0, ZQCL
  always_comb begin
    cmd_o        = '0;
    cmd_o.rank   = 2'b11;
    case (step_q)
      SW'(0): begin cmd_o.code = OP_DES; cmd_o.pause = 1'b1; end
      SW'(1): cmd_o.code = OP_PREA;
      SW'(2): begin cmd_o.code = OP_MRS; cmd_o.mr_idx = 3'd2; cmd_o.mr_dat = mr2_enc(cwl_i); end
      SW'(3): begin cmd_o.code = OP_MRS; cmd_o.mr_idx = 3'd3; end
      SW'(4): begin cmd_o.code = OP_MRS; cmd_o.mr_idx = 3'd1; cmd_o.mr_dat = MR1_VAL; end
      SW'(5): begin cmd_o.code = OP_MRS; cmd_o.mr_idx = 3'd0; cmd_o.mr_dat = mr0_enc(cl_i, wr_i); end
      default: cmd_o.code = OP_ZQL;
    endcase
  end
endmodule

// File: rtl/dcs_engine.sv
`timescale 1ns/1ps
module dcs_engine
  import dcs_pkg::*;
#(
  parameter int PAUSE_CYC = 250,
  parameter int CNT_W     = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                launch_i,
  input  cmd_t                cmd_i,
  input  logic [TMRD_W-1:0]   tmrd_i,
  input  logic [TZQ_W-1:0]    tzqcl_i,
  output logic                ready_o,
  output logic                busy_o,
  output logic                valid_o,
  output logic [CODE_W-1:0]   code_o,
  output logic [RANK_W-1:0]   rank_o,
  output logic [MRIX_W-1:0]   mr_idx_o,
  output logic [MRDAT_W-1:0]  mr_dat_o
);
  eng_st_e          st_q;
  cmd_t             cur_q;
  logic [CNT_W-1:0] cnt_q, gap;
  logic             known, fin;

  assign known = is_known(cur_q.code);

  always_comb begin
    gap = '0;
    if (known) begin
      if (cur_q.code == OP_MRS)      gap = CNT_W'(tmrd_i);
      else if (cur_q.code == OP_ZQL) gap = CNT_W'(tzqcl_i);
      else if (cur_q.pause)          gap = CNT_W'(PAUSE_CYC);
    end
  end

  // finishing cycle may launch the next command back-to-back
  assign fin     = (st_q == ST_ISSUE && gap <= CNT_W'(1)) ||
                   (st_q == ST_WAIT && cnt_q == CNT_W'(1));
  assign ready_o = (st_q == ST_IDLE) || fin;
  assign busy_o  = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
      cnt_q <= '0;
    end else if (launch_i && ready_o) begin
      cur_q <= cmd_i;
      st_q  <= ST_ISSUE;
    end else if (fin) begin
      st_q <= ST_IDLE;
    end else if (st_q == ST_ISSUE) begin
      st_q  <= ST_WAIT;
      cnt_q <= gap - CNT_W'(1);
    end else if (st_q == ST_WAIT) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign valid_o  = (st_q == ST_ISSUE) && known;
  assign code_o   = cur_q.code;
  assign rank_o   = cur_q.rank;
  assign mr_idx_o = cur_q.mr_idx;
  assign mr_dat_o = cur_q.mr_dat;
endmodule

// File: rtl/dram_cmd_seq.sv
`timescale 1ns/1ps
module dram_cmd_seq
  import dcs_pkg::*;
#(
  parameter int AW        = 3,
  parameter int PAUSE_CYC = 250,
  parameter int TMRD_RST  = 4,
  parameter int TZQCL_RST = 256,
  parameter int CL_RST    = 6,
  parameter int CWL_RST   = 5,
  parameter int WR_RST    = 6,
  parameter logic [MRDAT_W-1:0] MR1_VAL = 13'h040
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               pwrup_start_o,
  input  logic               pwrup_done_i,
  output logic               dram_cmd_valid_o,
  output logic [3:0]         dram_cmd_o,
  output logic [1:0]         dram_rank_o,
  output logic [2:0]         dram_mr_idx_o,
  output logic [12:0]        dram_mr_data_o
);
  localparam int CNT_W = (TZQ_W > $clog2(PAUSE_CYC + 1)) ? TZQ_W : $clog2(PAUSE_CYC + 1);

  logic              busy_any, eng_busy, eng_ready, init_active, init_trig;
  logic              sw_acc, launch, err_q;
  cmd_t              sw_cmd, init_cmd, sel_cmd;
  logic [TMRD_W-1:0] tmrd_q;
  logic [TZQ_W-1:0]  tzqcl_q;
  logic [3:0]        cl_q, cwl_q;
  logic [4:0]        wr_q;

  assign busy_any = eng_busy || init_active;
  assign launch   = init_active || sw_acc;
  assign sel_cmd  = init_active ? init_cmd : sw_cmd;

  dcs_regs #(
    .AW(AW), .TMRD_RST(TMRD_RST), .TZQCL_RST(TZQCL_RST),
    .CL_RST(CL_RST), .CWL_RST(CWL_RST), .WR_RST(WR_RST)
  ) regs_i (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy_any), .cmd_acc_o(sw_acc), .sw_cmd_o(sw_cmd),
    .pwr_req_o(pwrup_start_o), .pwr_done_i(pwrup_done_i), .err_o(err_q),
    .tmrd_o(tmrd_q), .tzqcl_o(tzqcl_q), .cl_o(cl_q), .cwl_o(cwl_q), .wr_o(wr_q),
    .init_trig_o(init_trig)
  );

  dcs_init_seq #(.MR1_VAL(MR1_VAL)) init_i (
    .clk_i, .rst_ni,
    .trig_i(init_trig), .acc_i(init_active && eng_ready),
    .cl_i(cl_q), .cwl_i(cwl_q), .wr_i(wr_q),
    .active_o(init_active), .cmd_o(init_cmd)
  );

  dcs_engine #(.PAUSE_CYC(PAUSE_CYC), .CNT_W(CNT_W)) eng_i (
    .clk_i, .rst_ni,
    .launch_i(launch), .cmd_i(sel_cmd), .tmrd_i(tmrd_q), .tzqcl_i(tzqcl_q),
    .ready_o(eng_ready), .busy_o(eng_busy),
    .valid_o(dram_cmd_valid_o), .code_o(dram_cmd_o), .rank_o(dram_rank_o),
    .mr_idx_o(dram_mr_idx_o), .mr_dat_o(dram_mr_data_o)
  );
endmodule

// File: rtl/dcs_chk.sv
`timescale 1ns/1ps
module dcs_chk
  import dcs_pkg::*;
#(
  parameter int AW = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [AW-1:0]      reg_addr_i,
  input logic [31:0]        reg_wdata_i,
  input logic               busy_i,
  input logic               err_i,
  input logic [TMRD_W-1:0]  tmrd_i,
  input logic [TZQ_W-1:0]   tzqcl_i,
  input logic               pwr_start_i,
  input logic               pwr_done_i,
  input logic               valid_i,
  input logic [CODE_W-1:0]  code_i
);
  logic [TZQ_W-1:0] since_q, mrd_need_q, zq_need_q;
  logic             cmd_wr;
  logic             unused_wd;

  assign unused_wd = ^reg_wdata_i[30:4];
  assign cmd_wr    = reg_we_i && (reg_addr_i == AW'(ADR_CMD)) && reg_wdata_i[START_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q    <= '0;
      mrd_need_q <= '0;
      zq_need_q  <= '0;
    end else if (valid_i) begin
      since_q    <= TZQ_W'(1);
      mrd_need_q <= (code_i == OP_MRS) ? TZQ_W'(tmrd_i) : '0;
      zq_need_q  <= (code_i == OP_ZQL) ? tzqcl_i : '0;
    end else if (since_q != '1) begin
      since_q <= since_q + 1'b1;
    end
  end

  // R2
  known_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> is_known(code_i));

  // R2
  unknown_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !busy_i && !is_known(reg_wdata_i[3:0])) |=> !valid_i);

  // R3
  strobe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> busy_i);

  // R4
  busy_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && busy_i) |=> err_i);

  // R5
  mrd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> since_q >= mrd_need_q);

  // R6
  zqcl_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> since_q >= zq_need_q);

  // R7
  pwr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_start_i && pwr_done_i) |=> !pwr_start_i);
endmodule

bind dram_cmd_seq dcs_chk #(.AW(AW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .busy_i(busy_any), .err_i(err_q), .tmrd_i(tmrd_q), .tzqcl_i(tzqcl_q),
  .pwr_start_i(pwrup_start_o), .pwr_done_i(pwrup_done_i),
  .valid_i(dram_cmd_valid_o), .code_i(dram_cmd_o)
);

// File: tb/dram_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module dram_cmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pw_start, pw_done = 1'b0;
  logic        valid;
  logic [3:0]  code;
  logic [1:0]  rank;
  logic [2:0]  mridx;
  logic [12:0] mrdat;

  int n_chk = 0, n_bad = 0, cyc = 0, vcnt = 0;
  int rec_n = 0;
  logic rec_on = 1'b0;
  int rec_code[16], rec_rank[16], rec_idx[16], rec_dat[16], rec_t[16];

  always #2 clk = ~clk;

  dram_cmd_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pwrup_start_o(pw_start), .pwrup_done_i(pw_done),
    .dram_cmd_valid_o(valid), .dram_cmd_o(code), .dram_rank_o(rank),
    .dram_mr_idx_o(mridx), .dram_mr_data_o(mrdat)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && valid) begin
      vcnt <= vcnt + 1;
      if (rec_on && rec_n < 16) begin
        rec_code[rec_n] = int'(code);
        rec_rank[rec_n] = int'(rank);
        rec_idx[rec_n]  = int'(mridx);
        rec_dat[rec_n]  = int'(mrdat);
        rec_t[rec_n]    = cyc;
        rec_n = rec_n + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp<=100000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic busy_len(output int n);
    logic [31:0] d;
    n = 0;
    for (int i = 0; i < 3000; i++) begin
      rd(0, d);
      if (!d[31]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, d); chk("R3 reset cmd reg", d, 32'h0);
    rd(3, d); chk("R10 reset timing", d, 32'h0001_0004);
    rd(4, d); chk("R10 reset init cfg", d, 32'h0000_6560);
    chk("R7 reset pwrup_start", {31'b0, pw_start}, 32'h0);
    chk("R1 reset valid", {31'b0, valid}, 32'h0);
  endtask

  task automatic t_fields;
    int n;
    wr(0, 32'h8010_0002);
    chk("R1 refresh valid", {31'b0, valid}, 1);
    chk("R1 refresh code", {28'b0, code}, 2);
    chk("R1 refresh rank", {30'b0, rank}, 1);
    busy_len(n); chk("R3 refresh busy cycles", n, 1);
    wr(0, 32'h8030_0001);
    chk("R1 prea both ranks", {30'b0, rank}, 3);
    chk("R1 prea code", {28'b0, code}, 1);
    busy_len(n); chk("R3 prea busy cycles", n, 1);
    chk("R1 single strobe", {31'b0, valid}, 0);
    wr(0, 32'h8024_0183);
    chk("R1 mrs code", {28'b0, code}, 3);
    chk("R1 mrs rank", {30'b0, rank}, 2);
    chk("R1 mrs index", {29'b0, mridx}, 2);
    chk("R1 mrs payload", {19'b0, mrdat}, 32'h18);
    busy_len(n); chk("R5 mrs busy default tmrd", n, 4);
  endtask

  task automatic t_timing;
    logic [31:0] d;
    int n;
    wr(3, 32'h0000_1407);
    rd(3, d); chk("R10 timing readback", d, 32'h0000_1407);
    wr(0, 32'h8030_0003);
    busy_len(n); chk("R5 mrs busy tmrd=7", n, 7);
    wr(0, 32'h8030_0005);
    busy_len(n); chk("R6 zqcl busy tzqcl=20", n, 20);
    wr(3, 32'h0000_1400);
    wr(0, 32'h8030_0003);
    busy_len(n); chk("R5 mrs busy tmrd=0", n, 1);
    wr(3, 32'h0001_0004);
    wr(0, 32'h8030_0005);
    busy_len(n); chk("R6 zqcl busy default", n, 256);
  endtask

  task automatic t_codes;
    int n, v0;
    logic [3:0] bad_c[3] = '{4'd7, 4'd10, 4'd15};
    logic [3:0] ok_c[3]  = '{4'd6, 4'd8, 4'd9};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1; v0 = vcnt;
      wr(0, {8'h80, 8'h30, 12'h0, bad_c[i]});
      chk("R2 unknown no strobe", {31'b0, valid}, 0);
      busy_len(n); chk("R2 unknown busy one cycle", n, 1);
      @(negedge clk); #1;
      chk("R2 unknown strobe count", vcnt - v0, 0);
    end
    for (int i = 0; i < 3; i++) begin
      wr(0, {8'h80, 8'h30, 12'h0, ok_c[i]});
      chk("R2 known code strobe", {31'b0, valid}, 1);
      chk("R2 known code value", {28'b0, code}, {28'b0, ok_c[i]});
      busy_len(n);
    end
  endtask

  task automatic t_busy_write;
    logic [31:0] d;
    int v0;
    wr(3, 32'h0000_1404);
    @(negedge clk); #1; v0 = vcnt;
    wr(0, 32'h8030_0005);
    wr(0, 32'h8010_0002);
    repeat (30) @(negedge clk);
    #1;
    chk("R4 rejected write no strobe", vcnt - v0, 1);
    rd(2, d); chk("R4 error flag set", {31'b0, d[1]}, 1);
    rd(0, d); chk("R4 stored cmd kept", d, 32'h0030_0005);
    wr(2, 32'h2);
    rd(2, d); chk("R4 error flag cleared", {31'b0, d[1]}, 0);
    wr(3, 32'h0001_0004);
  endtask

  task automatic t_init(input int cl, input int cwl, input int wrv,
                        input int e_mr0, input int e_mr2);
    logic [31:0] d;
    int n;
    int e_code[7] = '{0, 1, 3, 3, 3, 3, 5};
    int e_idx[7]  = '{0, 0, 2, 3, 1, 0, 0};
    int e_gap[6]  = '{250, 1, 4, 4, 4, 4};
    int e_dat[7];
    e_dat = '{0, 0, e_mr2, 0, 32'h40, e_mr0, 0};
    wr(4, 32'(1 | (cl << 4) | (cwl << 8) | (wrv << 12)));
    wr(1, 32'h1);
    chk("R7 pwrup_start raised", {31'b0, pw_start}, 1);
    rd(2, d); chk("R7 status done low", {31'b0, d[0]}, 0);
    repeat (3) @(negedge clk);
    rec_n = 0; rec_on = 1'b1;
    pw_done = 1'b1;
    @(negedge clk);
    chk("R7 pwrup_start dropped", {31'b0, pw_start}, 0);
    rd(2, d); chk("R7 status done high", {31'b0, d[0]}, 1);
    rd(0, d); chk("R8 busy during init", {31'b0, d[31]}, 1);
    busy_len(n);
    rec_on = 1'b0;
    chk("R8 init command count", rec_n, 7);
    if (rec_n == 7) begin
      for (int i = 0; i < 7; i++) begin
        chk("R8 init code order", rec_code[i], e_code[i]);
        chk("R8 init rank both", rec_rank[i], 3);
        chk("R8 init mr index", rec_idx[i], e_idx[i]);
        chk("R9 init payload", rec_dat[i], e_dat[i]);
      end
      for (int i = 0; i < 6; i++)
        chk("R8 init spacing", rec_t[i+1] - rec_t[i], e_gap[i]);
    end
    pw_done = 1'b0;
    wr(4, 32'h0000_6560);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_timing();
    t_codes();
    t_busy_write();
    t_init(6, 8, 10, 32'hB20, 32'h18);
    t_init(11, 7, 8, 32'h970, 32'h10);
    t_init(12, 5, 16, 32'h102, 32'h0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule